// File: doc/BRIEF.md
# SD Read Block Transmitter

This block sends the data phase of SD read commands. The command engine gives it a sector number, a single- or multi-block flag and a bus width. The block then fetches 512-byte sectors through a small storage port that is addressed in 16-bit words, and shifts each sector out on the four DAT lines. Each line sends a start bit, its share of the payload, its own CRC16 and an end bit. The DAT lines are outputs only. The block never samples them and never signals busy.

The sector number is a high-capacity block index, so word address = sector × 256. The storage port follows a strict timing contract. The block raises a one-cycle read strobe, and the addressed word appears on the data input after that edge and stays there until the next strobe. When the address enters a new sector, it must stand still for at least eight cycles before the strobe. Inside a sector, one cycle of lead is enough. Each word is split little-endian: the low byte is sent first. Multi-block transfers continue through consecutive sectors until a stop request arrives.

Top module: `sd_rdblk_tx`

## Requirements
- R1: After reset, `busy` and `st_req` are 0 and all four DAT lines are driven high. The lines stay high whenever `busy` is 0.
- R2: The first storage address of a transfer equals the sector number × 256. Later words use consecutive addresses, and a multi-block transfer continues into the next sector.
- R3: `st_req` is a single-cycle pulse and occurs only while busy. Before a pulse whose address lies in a different 256-word sector than the previous pulse (or the first pulse), `st_addr` holds its value for at least 8 cycles. Before any other pulse, it holds for at least 1 cycle.
- R4: Byte 2n of a sector is the low byte of word n, and byte 2n+1 is its high byte. Bytes are sent in ascending order. Word 0x8200 at word address 0x0DF gives byte 0x1BE = 0x00 and byte 0x1BF = 0x82.
- R5: In 4-bit mode (`rd_wide`=1, latched at start), each byte goes out as the high nibble and then the low nibble, with nibble bit 3 on DAT3 and bit 0 on DAT0.
- R6: In 1-bit mode (`rd_wide`=0), payload bits go out on DAT0 most significant bit first, and DAT3..DAT1 stay high for the whole transfer.
- R7: Each active line sends a start bit of 0, then its payload bits, then its 16-bit CRC, then an end bit of 1. The CRC uses polynomial x^16+x^12+x^5+1 (0x1021), seed 0, covers that line's payload bits only, and is sent most significant bit first.
- R8: A single-block request (`rd_multi`=0) produces exactly one block, after which `busy` returns to 0.
- R9: A multi-block request sends consecutive sectors with at least 2 idle-high cycles between one block's end bit and the next start bit. A stop request raised during a block ends the transfer after that block's end bit.
- R10: A stop request raised in the idle gap between blocks prevents any further start bit, and `busy` falls.
- R11: `rd_start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD clock; all logic on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | One-cycle request to begin a read transfer |
| rd_multi | input | 1 | 1: multi-block transfer, 0: single block |
| rd_wide | input | 1 | 1: 4-bit bus, 0: 1-bit bus |
| rd_sector | input | 32 | Sector number of the first block |
| stop_req | input | 1 | Request to end a multi-block transfer |
| busy | output | 1 | Transfer in progress |
| st_req | output | 1 | Storage read strobe |
| st_addr | output | 40 | Storage word address |
| st_data | input | 16 | Storage read word |
| dat_o | output | 4 | DAT3..DAT0 line drive |

## Verification
A wrong address counter or lead counter shows up on the storage port at the very next strobe: the strobe address jumps or rises too early. It also corrupts the payload bytes of that block. A wrong nibble order, byte order or shift position shows up in the first payload byte. A broken CRC register is visible 16 cycles after the payload ends, and a missed stop shows up as an extra start bit about ten cycles after an end bit. A stuck state machine shows up as `busy` never falling.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;
  localparam int DAT_LINES = 4;
  localparam int CRC_LEN   = 16;
  localparam logic [CRC_LEN-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_REQ0,
    ST_START,
    ST_DATA,
    ST_CRC,
    ST_END
  } tx_state_e;
endpackage

// File: rtl/sdtx_addr_gen.sv
module sdtx_addr_gen #(
  parameter int ADDR_W     = 40,
  parameter int SECT_W     = 32,
  parameter int WORD_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [SECT_W-1:0] sector,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] base;

  always_comb begin
    base   = ADDR_W'(sector) << WORD_SHIFT;
    addr_d = addr_q;
    if (load_en) begin
      addr_d = base;
    end else if (step_en) begin
      addr_d = addr_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_en || step_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/sdtx_crc16_lane.sv
module sdtx_crc16_lane
  import sdtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd_en,
  input  logic shift_en,
  input  logic bit_in,
  output logic msb
);
  logic [CRC_LEN-1:0] crc_q;
  logic [CRC_LEN-1:0] crc_d;
  logic               fb;

  always_comb begin
    fb    = crc_q[CRC_LEN-1] ^ bit_in;
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (upd_en) begin
      crc_d = {crc_q[CRC_LEN-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end else if (shift_en) begin
      crc_d = {crc_q[CRC_LEN-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (clr || upd_en || shift_en) begin
      crc_q <= crc_d;
    end
  end

  assign msb = crc_q[CRC_LEN-1];
endmodule

// File: rtl/sdtx_word_shifter.sv
module sdtx_word_shifter
  import sdtx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic                 shift_en,
  input  logic                 wide,
  input  logic [DATA_W-1:0]    word_in,
  output logic [DAT_LINES-1:0] nib
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load_en) begin
      // low byte leaves first, each byte most significant bit first
      sh_d = {word_in[HALF-1:0], word_in[DATA_W-1:HALF]};
    end else if (shift_en) begin
      sh_d = wide ? (sh_q << DAT_LINES) : (sh_q << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load_en || shift_en) begin
      sh_q <= sh_d;
    end
  end

  assign nib = sh_q[DATA_W-1 -: DAT_LINES];
endmodule

// File: rtl/sd_rdblk_tx.sv
module sd_rdblk_tx
  import sdtx_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int SECT_W    = 32,
  parameter int DATA_W    = 16,
  parameter int BLK_BYTES = 512,
  parameter int LEAD_NEW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_start,
  input  logic                 rd_multi,
  input  logic                 rd_wide,
  input  logic [SECT_W-1:0]    rd_sector,
  input  logic                 stop_req,
  output logic                 busy,
  output logic                 st_req,
  output logic [ADDR_W-1:0]    st_addr,
  input  logic [DATA_W-1:0]    st_data,
  output logic [DAT_LINES-1:0] dat_o
);
  localparam int WORDS    = BLK_BYTES / (DATA_W / 8);
  localparam int WIDX_W   = $clog2(WORDS);
  localparam int LEAD_W   = $clog2(LEAD_NEW + 1);
  localparam int SLOT_MAX = (DATA_W > CRC_LEN) ? DATA_W : CRC_LEN;
  localparam int SLOT_W   = $clog2(SLOT_MAX);
  localparam logic [SLOT_W-1:0] LAST_NARROW = SLOT_W'(DATA_W - 1);
  localparam logic [SLOT_W-1:0] LAST_WIDE   = SLOT_W'(DATA_W / DAT_LINES - 1);
  localparam logic [SLOT_W-1:0] LAST_CRC    = SLOT_W'(CRC_LEN - 1);
  localparam logic [WIDX_W-1:0] WIDX_LAST   = WIDX_W'(WORDS - 1);
  localparam logic [WIDX_W-1:0] WIDX_PENULT = WIDX_W'(WORDS - 2);
  localparam logic [LEAD_W-1:0] LEAD_LAST   = LEAD_W'(LEAD_NEW - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  tx_state_e           state_q, state_d;
  logic [SLOT_W-1:0]   cnt_q, cnt_d;
  logic [WIDX_W-1:0]   widx_q, widx_d;
  logic [LEAD_W-1:0]   lead_q, lead_d;
  logic                wide_q, wide_d;
  logic                multi_q, multi_d;
  logic                stop_q, stop_d;

  logic                load_addr, step_addr;
  logic                sh_load, sh_shift;
  logic                crc_clr, crc_upd, crc_shift;
  logic [SLOT_W-1:0]   last_slot;
  logic                stop_now;

  logic [DAT_LINES-1:0] nib;
  logic [DAT_LINES-1:0] pay_bits;
  logic [DAT_LINES-1:0] crc_top;
  logic [DAT_LINES-1:0] crc_bits;

  assign last_slot = wide_q ? LAST_WIDE : LAST_NARROW;
  assign stop_now  = stop_q | stop_req;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    widx_d    = widx_q;
    lead_d    = lead_q;
    wide_d    = wide_q;
    multi_d   = multi_q;
    stop_d    = stop_q | (stop_req && (state_q != ST_IDLE));
    load_addr = 1'b0;
    step_addr = 1'b0;
    sh_load   = 1'b0;
    sh_shift  = 1'b0;
    crc_clr   = 1'b0;
    crc_upd   = 1'b0;
    crc_shift = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        stop_d = 1'b0;
        if (rd_start) begin
          load_addr = 1'b1;
          wide_d    = rd_wide;
          multi_d   = rd_multi;
          lead_d    = '0;
          state_d   = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (stop_now) begin
          state_d = ST_IDLE;
        end else if (lead_q == LEAD_LAST) begin
          state_d = ST_REQ0;
        end else begin
          lead_d = lead_q + LEAD_W'(1);
        end
      end
      ST_REQ0: begin
        state_d = ST_START;
      end
      ST_START: begin
        crc_clr   = 1'b1;
        sh_load   = 1'b1;
        cnt_d     = '0;
        widx_d    = '0;
        step_addr = (WORDS > 1);
        state_d   = ST_DATA;
      end
      ST_DATA: begin
        crc_upd = 1'b1;
        if (cnt_q == last_slot) begin
          cnt_d = '0;
          if (widx_q == WIDX_LAST) begin
            state_d = ST_CRC;
          end else begin
            sh_load   = 1'b1;
            widx_d    = widx_q + WIDX_W'(1);
            step_addr = (widx_q < WIDX_PENULT);
          end
        end else begin
          sh_shift = 1'b1;
          cnt_d    = cnt_q + SLOT_W'(1);
        end
      end
      ST_CRC: begin
        crc_shift = 1'b1;
        if (cnt_q == LAST_CRC) begin
          cnt_d   = '0;
          state_d = ST_END;
        end else begin
          cnt_d = cnt_q + SLOT_W'(1);
        end
      end
      ST_END: begin
        if (!multi_q || stop_now) begin
          state_d = ST_IDLE;
        end else begin
          step_addr = 1'b1;
          lead_d    = '0;
          state_d   = ST_LEAD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      widx_q  <= '0;
      lead_q  <= '0;
      wide_q  <= 1'b0;
      multi_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      widx_q  <= widx_d;
      lead_q  <= lead_d;
      wide_q  <= wide_d;
      multi_q <= multi_d;
      stop_q  <= stop_d;
    end
  end

  sdtx_addr_gen #(
    .ADDR_W    (ADDR_W),
    .SECT_W    (SECT_W),
    .WORD_SHIFT(WIDX_W)
  ) u_addr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_en(load_addr),
    .step_en(step_addr),
    .sector (rd_sector),
    .addr   (st_addr)
  );

  sdtx_word_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_en (sh_load),
    .shift_en(sh_shift),
    .wide    (wide_q),
    .word_in (st_data),
    .nib     (nib)
  );

  assign pay_bits = wide_q ? nib : {{(DAT_LINES-1){1'b1}}, nib[DAT_LINES-1]};

  for (genvar g = 0; g < DAT_LINES; g++) begin : g_lane
    sdtx_crc16_lane u_crc (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .clr     (crc_clr),
      .upd_en  (crc_upd),
      .shift_en(crc_shift),
      .bit_in  (pay_bits[g]),
      .msb     (crc_top[g])
    );
  end

  assign crc_bits = wide_q ? crc_top : {{(DAT_LINES-1){1'b1}}, crc_top[0]};

  always_comb begin
    unique case (state_q)
      ST_START: dat_o = wide_q ? '0 : {{(DAT_LINES-1){1'b1}}, 1'b0};
      ST_DATA:  dat_o = pay_bits;
      ST_CRC:   dat_o = crc_bits;
      default:  dat_o = '1;
    endcase
  end

  assign busy   = (state_q != ST_IDLE);
  assign st_req = (state_q == ST_REQ0) ||
                  ((state_q == ST_DATA) && (cnt_q == SLOT_W'(1)) && (widx_q != WIDX_LAST));
endmodule

// File: rtl/sdtx_checker.sv
module sdtx_checker #(
  parameter int ADDR_W     = 40,
  parameter int SECT_SHIFT = 8,
  parameter int LEAD_NEW   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              st_req,
  input logic [ADDR_W-1:0] st_addr,
  input logic [3:0]        dat_o,
  input logic              wide_q
);
  logic [ADDR_W-1:0]            prev_addr_q;
  logic [7:0]                   run_q;
  logic [ADDR_W-SECT_SHIFT-1:0] last_sect_q;
  logic                         have_last_q;
  logic                         same_now;
  logic                         new_sect;

  assign same_now = (st_addr == prev_addr_q);
  assign new_sect = !have_last_q || (st_addr[ADDR_W-1:SECT_SHIFT] != last_sect_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr_q <= '0;
      run_q       <= '0;
      last_sect_q <= '0;
      have_last_q <= 1'b0;
    end else begin
      prev_addr_q <= st_addr;
      if (!same_now) begin
        run_q <= 8'd1;
      end else if (run_q != 8'hFF) begin
        run_q <= run_q + 8'd1;
      end
      if (st_req) begin
        last_sect_q <= st_addr[ADDR_W-1:SECT_SHIFT];
        have_last_q <= 1'b1;
      end
    end
  end

  a_r1_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dat_o == 4'hF));

  a_r3_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |=> !st_req);

  a_r3_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> busy);

  a_r3_addr_lead_short: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_req) |-> (same_now && (run_q >= 8'd1)));

  a_r3_addr_lead_sector: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_req) && new_sect) |-> (same_now && (run_q >= 8'(LEAD_NEW))));

  a_r6_narrow_upper_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |-> (dat_o[3:1] == 3'b111));
endmodule

bind sd_rdblk_tx sdtx_checker #(
  .ADDR_W    (ADDR_W),
  .SECT_SHIFT(WIDX_W),
  .LEAD_NEW  (LEAD_NEW)
) u_sdtx_chk (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .busy   (busy),
  .st_req (st_req),
  .st_addr(st_addr),
  .dat_o  (dat_o),
  .wide_q (wide_q)
);

// File: tb/sd_rdblk_tx_bench.sv
module sd_rdblk_tx_bench;
  typedef struct packed {
    logic [31:0] sector;
    logic        wide;
    logic        follows;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        rd_start;
  logic        rd_multi;
  logic        rd_wide;
  logic [31:0] rd_sector;
  logic        stop_req;
  logic        busy;
  logic        st_req;
  logic [39:0] st_addr;
  logic [15:0] st_data;
  logic [3:0]  dat_o;

  int n_cmp;
  int n_bad;
  int cyc;
  int frames_started;
  int frames_done;
  int lead_bad;
  bit finished;
  item_t exp_q[$];
  logic [7:0] rx_bytes [512];

  sd_rdblk_tx u_sd_rdblk_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .rd_multi (rd_multi),
    .rd_wide  (rd_wide),
    .rd_sector(rd_sector),
    .stop_req (stop_req),
    .busy     (busy),
    .st_req   (st_req),
    .st_addr  (st_addr),
    .st_data  (st_data),
    .dat_o    (dat_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [39:0] a);
    if (a == 40'h00_0000_00DF) return 16'h8200;
    return {a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'h3C, a[7:0] + a[31:24] + a[23:16] + 8'h11};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [31:0] sect, input int i);
    logic [39:0] a;
    logic [15:0] w;
    a = ({8'h00, sect} << 8) + 40'(i / 2);
    w = mem_f(a);
    return (i % 2 == 1) ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  // storage model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_data <= 16'h0000;
    else if (st_req) st_data <= mem_f(st_addr);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) cyc++;

  // storage-port lead monitor (R3)
  initial begin : lead_mon
    logic [39:0] prev_a;
    logic [31:0] last_sect;
    bit          have_last;
    bit          prev_req;
    int          run;
    prev_a = '0; run = 0; have_last = 0; prev_req = 0; last_sect = '0;
    forever begin
      @(negedge clk);
      if (st_req && !prev_req) begin
        if (st_addr != prev_a) lead_bad++;
        else if ((!have_last || st_addr[39:8] != last_sect) && run < 8) lead_bad++;
        else if (run < 1) lead_bad++;
        have_last = 1;
        last_sect = st_addr[39:8];
      end
      if (st_req && prev_req) lead_bad++;
      if (st_addr == prev_a) run++;
      else run = 1;
      prev_a   = st_addr;
      prev_req = st_req;
    end
  end

  // frame monitor / scoreboard
  initial begin : frame_mon
    int end_cyc;
    end_cyc = 0;
    forever begin
      @(negedge clk);
      if (rst_n && busy && dat_o[0] == 1'b0) begin
        item_t it;
        logic [15:0] crc_exp [4];
        logic [15:0] crc_rx [4];
        int bad_bytes;
        int narrow_bad;
        int nslots;
        frames_started++;
        if (exp_q.size() == 0) begin
          check(0, "R10", "unexpected block start", 1, 0);
          it = '{sector: 32'h0, wide: 1'b1, follows: 1'b0};
        end else begin
          it = exp_q.pop_front();
        end
        if (it.follows)
          check((cyc - end_cyc - 1) >= 2, "R9", "idle gap between blocks", 64'(cyc - end_cyc - 1), 2);
        check(dat_o == (it.wide ? 4'h0 : 4'hE), "R7", "start bit", dat_o, it.wide ? 4'h0 : 4'hE);
        for (int l = 0; l < 4; l++) begin crc_exp[l] = '0; crc_rx[l] = '0; end
        narrow_bad = 0;
        nslots = it.wide ? 1024 : 4096;
        for (int n = 0; n < nslots; n++) begin
          @(negedge clk);
          if (it.wide) begin
            for (int l = 0; l < 4; l++) crc_exp[l] = crc_step(crc_exp[l], dat_o[l]);
            if (n % 2 == 0) rx_bytes[n / 2][7:4] = dat_o;
            else rx_bytes[n / 2][3:0] = dat_o;
          end else begin
            crc_exp[0] = crc_step(crc_exp[0], dat_o[0]);
            rx_bytes[n / 8][7 - (n % 8)] = dat_o[0];
            if (dat_o[3:1] != 3'b111) narrow_bad++;
          end
        end
        for (int k = 0; k < 16; k++) begin
          @(negedge clk);
          for (int l = 0; l < 4; l++) crc_rx[l] = {crc_rx[l][14:0], dat_o[l]};
          if (!it.wide && dat_o[3:1] != 3'b111) narrow_bad++;
        end
        @(negedge clk);
        check(dat_o == 4'hF, "R7", "end bit", dat_o, 4'hF);
        end_cyc = cyc;
        bad_bytes = 0;
        for (int i = 0; i < 512; i++)
          if (rx_bytes[i] !== exp_byte(it.sector, i)) bad_bytes++;
        if (it.wide)
          check(bad_bytes == 0, "R5", "payload bytes (4-bit) wrong count", 64'(bad_bytes), 0);
        else
          check(bad_bytes == 0, "R6", "payload bytes (1-bit) wrong count", 64'(bad_bytes), 0);
        check(bad_bytes == 0, "R2", "sector content matches address", 64'(bad_bytes), 0);
        if (it.wide) begin
          for (int l = 0; l < 4; l++)
            check(crc_rx[l] == crc_exp[l], "R7", "line CRC16", crc_rx[l], crc_exp[l]);
        end else begin
          check(crc_rx[0] == crc_exp[0], "R7", "DAT0 CRC16", crc_rx[0], crc_exp[0]);
          check(narrow_bad == 0, "R6", "upper lines high in 1-bit mode", 64'(narrow_bad), 0);
        end
        if (it.sector == 32'h0) begin
          check(rx_bytes[12'h1BE] == 8'h00, "R4", "byte 0x1BE", rx_bytes[12'h1BE], 8'h00);
          check(rx_bytes[12'h1BF] == 8'h82, "R4", "byte 0x1BF", rx_bytes[12'h1BF], 8'h82);
        end
        frames_done++;
      end
    end
  end

  task automatic launch(input logic [31:0] sect, input bit multi, input bit wide, input int nblk);
    for (int k = 0; k < nblk; k++)
      exp_q.push_back('{sector: sect + 32'(k), wide: wide, follows: (k > 0)});
    @(negedge clk);
    rd_start  = 1'b1;
    rd_multi  = multi;
    rd_wide   = wide;
    rd_sector = sect;
    @(negedge clk);
    rd_start = 1'b0;
    while (!st_req) @(negedge clk);
    check(st_addr == ({8'h00, sect} << 8), "R2", "first storage address", st_addr, {8'h00, sect} << 8);
  endtask

  task automatic pulse_stop();
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    int base;
    rst_n = 1'b0; rd_start = 1'b0; rd_multi = 1'b0; rd_wide = 1'b0;
    rd_sector = '0; stop_req = 1'b0;
    n_cmp = 0; n_bad = 0; cyc = 0; frames_started = 0; frames_done = 0;
    lead_bad = 0; finished = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(st_req == 1'b0, "R1", "st_req after reset", st_req, 0);
    check(dat_o == 4'hF, "R1", "DAT idle after reset", dat_o, 4'hF);

    // single block, 4-bit, sector 0 (R4, R5, R8)
    base = frames_done;
    launch(32'h0, 1'b0, 1'b1, 1);
    wait_idle();
    check(frames_done - base == 1, "R8", "single block count", 64'(frames_done - base), 1);
    check(dat_o == 4'hF, "R1", "DAT idle after transfer", dat_o, 4'hF);

    // single block, 1-bit (R6)
    base = frames_done;
    launch(32'h3, 1'b0, 1'b0, 1);
    wait_idle();
    check(frames_done - base == 1, "R8", "single 1-bit block count", 64'(frames_done - base), 1);

    // multi 4-bit, stray start while busy (R11), stop in third block (R9)
    base = frames_started;
    launch(32'h10, 1'b1, 1'b1, 3);
    @(negedge clk);
    rd_start = 1'b1; rd_sector = 32'h999; rd_multi = 1'b0; rd_wide = 1'b0;
    @(negedge clk);
    rd_start = 1'b0;
    wait (frames_started == base + 3);
    pulse_stop();
    wait_idle();
    check(frames_started - base == 3, "R9", "blocks before stop", 64'(frames_started - base), 3);
    check(exp_q.size() == 0, "R11", "stray start left no trace", 64'(exp_q.size()), 0);

    // multi 4-bit, stop in gap after first block (R10)
    base = frames_done;
    launch(32'hC000_0007, 1'b1, 1'b1, 1);
    wait (frames_done == base + 1);
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    wait_idle();
    repeat (30) @(negedge clk);
    check(frames_started == frames_done && frames_done - base == 1, "R10",
          "no block after gap stop", 64'(frames_started - base), 1);
    check(busy == 1'b0, "R10", "busy falls after gap stop", busy, 0);

    // multi 1-bit across sector boundary, stop in second block (R2, R9)
    base = frames_started;
    launch(32'h0000_00FF, 1'b1, 1'b0, 2);
    wait (frames_started == base + 2);
    pulse_stop();
    wait_idle();
    check(frames_started - base == 2, "R9", "1-bit blocks before stop", 64'(frames_started - base), 2);

    check(lead_bad == 0, "R3", "storage address lead violations", 64'(lead_bad), 0);
    finish_run();
  end
endmodule